// File: doc/BRIEF.md
# Programmable Line Clamp and Blank Pulse Generator

This block drives two per-line timing strobes for the readout front end of an image sensor: a dark-level clamp strobe and a pixel blanking strobe. Both are active low. Each strobe follows a waveform that is set per line by a start level and two pixel positions. At each of the two positions the level flips. A pixel counter runs along the line and a line counter runs down the field. Both counters come from the pixel clock and the line and field sync pulses.

Four waveform sets are kept for each strobe, one per vertical sequence. Three programmable change lines split the field into regions, and the region that holds the current line picks the set in use. Each strobe also has three line windows that apply to the whole field. Inside any enabled window the strobe is held at its inactive level, whatever sequence is active. All settings are written through a simple address/data port into a staging bank. That bank is copied into the working bank on field sync, so a field never sees a half-written setting.

Top module: `lcb_line_pulse_gen`

## Requirements
- R1: While reset is high, and at the first sample after it, both outputs are high. Reset loads every waveform set with start level 1 and both flip positions 8191. Every window gets start 8191 and end 0. Every change line gets 8191.
- R2: The pixel count is 13 bits. It returns to 0 on a clock where hsync or vsync is high, and otherwise counts up by one per clock, holding at 8191. The line count is 13 bits. It returns to 0 on vsync, counts up by one on hsync without vsync, and holds at 8191.
- R3: A strobe's level is start_level XOR (pixel >= flip_a) XOR (pixel >= flip_b). Either flip position may be the smaller one, and a position the line never reaches causes no flip.
- R4: The outputs are active low. A 0 means the strobe is asserted, and with the reset settings both strobes stay at 1 for the whole field.
- R5: The sequence used on a line is the count of change lines that are less than or equal to that line number, 0 to 3. The waveform comes from that sequence's set.
- R6: A window covers the lines from its start to its end, both ends included. Any enabled window that covers the current line forces its strobe to 1.
- R7: A window is disabled when its start is 8191 or its start is greater than its end. A window whose lines lie past the end of the field has no effect.
- R8: The windows of a strobe apply in every sequence region and are not kept per sequence.
- R9: Writes land in a staging bank. The working bank takes the whole staging bank on each clock where vsync is high. A write has no effect on the outputs before the next vsync, and a write in the same cycle as vsync waits for the following one.
- R10: The address is 8 bits. With bits[7:6]=00, a waveform field is selected: bits[5:4] pick the sequence, bit[3] the strobe (0 clamp, 1 blank), bits[1:0] the field (0 start level taken from data bit 0, 1 flip_a, 2 flip_b, 3 ignored). With bits[7:6]=01, a window is selected: bit[3] picks the strobe, bits[2:1] the window (0 to 2, 3 ignored), bit[0] start (0) or end (1). With bits[7:6]=10, bits[1:0] pick change line 0 to 2 (3 ignored). Writes with bits[7:6]=11 are ignored.
- R11: An output after clock edge k+1 is the level computed from the counters and working bank present after edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Line start pulse, one clock wide |
| vsync | input | 1 | Field start pulse, one clock wide, given together with hsync |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 8 | Setting address (map in R10) |
| wr_data | input | 13 | Setting value |
| clamp_n | output | 1 | Dark-level clamp strobe, active low |
| blank_n | output | 1 | Pixel blanking strobe, active low |

## Verification
The hardest case to reach from the ports is a window crossing a sequence boundary while staged writes wait for the next field. Here the output depends on the bank in use, the region count and the window test all at once. The stimulus programs three change lines and windows that cover lines from more than one region. It writes new settings in the middle of a field and runs that field out unchanged. It then crosses vsync so the new bank takes hold. A flip position below the other one, a flip at pixel 0 and flips past the line end are placed on purpose. This covers the cancelling and never-reached cases of the XOR level rule.

// File: rtl/lcb_pkg.sv
`timescale 1ns/1ps
package lcb_pkg;

    localparam int CNT_W     = 13;
    localparam int ADDR_W    = 8;
    localparam int NUM_PULSE = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_MAX = '1;

    // one waveform set: start level and two flip positions
    typedef struct packed {
        logic start_lvl;
        cnt_t flip_a;
        cnt_t flip_b;
    } wave_t;

    // one line window, inclusive
    typedef struct packed {
        cnt_t first;
        cnt_t last;
    } window_t;

    typedef enum logic [1:0] {
        SPACE_WAVE   = 2'b00,
        SPACE_WINDOW = 2'b01,
        SPACE_CHANGE = 2'b10,
        SPACE_NONE   = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        FLD_LEVEL  = 2'd0,
        FLD_FLIP_A = 2'd1,
        FLD_FLIP_B = 2'd2,
        FLD_SPARE  = 2'd3
    } wfield_e;

    localparam wave_t   WAVE_RST   = '{start_lvl: 1'b1, flip_a: CNT_MAX, flip_b: CNT_MAX};
    localparam window_t WINDOW_RST = '{first: CNT_MAX, last: '0};

    function automatic cnt_t sat_inc(cnt_t v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    function automatic logic wave_level(wave_t w, cnt_t pix);
        return w.start_lvl ^ (pix >= w.flip_a) ^ (pix >= w.flip_b);
    endfunction

    function automatic logic window_covers(window_t w, cnt_t line);
        return (w.first != CNT_MAX) && (w.first <= line) && (line <= w.last);
    endfunction

endpackage

// File: rtl/lcb_counters.sv
`timescale 1ns/1ps
module lcb_counters
    import lcb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hsync,
    input  logic vsync,
    output cnt_t pix,
    output cnt_t line
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= '0;
        end else if (hsync || vsync) begin
            pix <= '0;
        end else begin
            pix <= sat_inc(pix);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
        end else if (vsync) begin
            line <= '0;
        end else if (hsync) begin
            line <= sat_inc(line);
        end
    end

endmodule

// File: rtl/lcb_regbank.sv
`timescale 1ns/1ps
module lcb_regbank
    import lcb_pkg::*;
#(
    parameter int NUM_SEQ  = 4,
    parameter int NUM_MASK = 3
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        wr_en,
    input  logic [ADDR_W-1:0]                           wr_addr,
    input  cnt_t                                        wr_data,
    input  logic                                        commit,
    output wave_t   [NUM_PULSE-1:0][NUM_SEQ-1:0]        act_wave,
    output window_t [NUM_PULSE-1:0][NUM_MASK-1:0]       act_win,
    output cnt_t    [NUM_SEQ-2:0]                       act_chg
);

    wave_t   [NUM_PULSE-1:0][NUM_SEQ-1:0]  stg_wave;
    window_t [NUM_PULSE-1:0][NUM_MASK-1:0] stg_win;
    cnt_t    [NUM_SEQ-2:0]                 stg_chg;

    space_e      space;
    logic [1:0]  seq_idx;
    logic        pulse_idx;
    wfield_e     fld;
    logic [1:0]  area;
    logic        edge_sel;
    logic [1:0]  chg_idx;

    always_comb begin
        space     = space_e'(wr_addr[7:6]);
        seq_idx   = wr_addr[5:4];
        pulse_idx = wr_addr[3];
        fld       = wfield_e'(wr_addr[1:0]);
        area      = wr_addr[2:1];
        edge_sel  = wr_addr[0];
        chg_idx   = wr_addr[1:0];
    end

    // staging bank
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PULSE; p++) begin
                for (int s = 0; s < NUM_SEQ; s++) stg_wave[p][s] <= WAVE_RST;
                for (int a = 0; a < NUM_MASK; a++) stg_win[p][a] <= WINDOW_RST;
            end
            for (int k = 0; k < NUM_SEQ-1; k++) stg_chg[k] <= CNT_MAX;
        end else if (wr_en) begin
            case (space)
                SPACE_WAVE: begin
                    if (int'(seq_idx) < NUM_SEQ) begin
                        case (fld)
                            FLD_LEVEL:  stg_wave[pulse_idx][seq_idx].start_lvl <= wr_data[0];
                            FLD_FLIP_A: stg_wave[pulse_idx][seq_idx].flip_a    <= wr_data;
                            FLD_FLIP_B: stg_wave[pulse_idx][seq_idx].flip_b    <= wr_data;
                            default: ;
                        endcase
                    end
                end
                SPACE_WINDOW: begin
                    if (int'(area) < NUM_MASK) begin
                        if (edge_sel) stg_win[pulse_idx][area].last  <= wr_data;
                        else          stg_win[pulse_idx][area].first <= wr_data;
                    end
                end
                SPACE_CHANGE: begin
                    if (int'(chg_idx) < NUM_SEQ-1) stg_chg[chg_idx] <= wr_data;
                end
                default: ;
            endcase
        end
    end

    // working bank, replaced only at field start
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NUM_PULSE; p++) begin
                for (int s = 0; s < NUM_SEQ; s++) act_wave[p][s] <= WAVE_RST;
                for (int a = 0; a < NUM_MASK; a++) act_win[p][a] <= WINDOW_RST;
            end
            for (int k = 0; k < NUM_SEQ-1; k++) act_chg[k] <= CNT_MAX;
        end else if (commit) begin
            act_wave <= stg_wave;
            act_win  <= stg_win;
            act_chg  <= stg_chg;
        end
    end

endmodule

// File: rtl/lcb_pulse_lane.sv
`timescale 1ns/1ps
module lcb_pulse_lane
    import lcb_pkg::*;
#(
    parameter int NUM_SEQ  = 4,
    parameter int NUM_MASK = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  cnt_t                          pix,
    input  cnt_t                          line,
    input  wave_t   [NUM_SEQ-1:0]         waves,
    input  window_t [NUM_MASK-1:0]        wins,
    input  cnt_t    [NUM_SEQ-2:0]         chg,
    output logic                          mask_hit,
    output logic                          pulse_n
);

    localparam int SEL_W = (NUM_SEQ > 1) ? $clog2(NUM_SEQ) : 1;

    logic [SEL_W-1:0]    sel;
    logic [NUM_MASK-1:0] hits;
    wave_t               cur_wave;

    // region = number of change lines already reached
    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_SEQ-1; k++) begin
            if (line >= chg[k]) sel = sel + 1'b1;
        end
    end

    assign cur_wave = waves[sel];

    for (genvar a = 0; a < NUM_MASK; a++) begin : g_win
        assign hits[a] = window_covers(wins[a], line);
    end

    assign mask_hit = |hits;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_n <= 1'b1;
        end else begin
            pulse_n <= mask_hit ? 1'b1 : wave_level(cur_wave, pix);
        end
    end

endmodule

// File: rtl/lcb_line_pulse_gen.sv
`timescale 1ns/1ps
module lcb_line_pulse_gen
    import lcb_pkg::*;
#(
    parameter int NUM_SEQ  = 4,
    parameter int NUM_MASK = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [12:0]       wr_data,
    output logic              clamp_n,
    output logic              blank_n
);

    cnt_t pix;
    cnt_t line;

    wave_t   [NUM_PULSE-1:0][NUM_SEQ-1:0]  act_wave;
    window_t [NUM_PULSE-1:0][NUM_MASK-1:0] act_win;
    cnt_t    [NUM_SEQ-2:0]                 act_chg;

    logic [NUM_PULSE-1:0] mask_hit;
    logic [NUM_PULSE-1:0] pulse_n;

    lcb_counters u_cnt (
        .clk   (clk),
        .rst   (rst),
        .hsync (hsync),
        .vsync (vsync),
        .pix   (pix),
        .line  (line)
    );

    lcb_regbank #(
        .NUM_SEQ  (NUM_SEQ),
        .NUM_MASK (NUM_MASK)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit   (vsync),
        .act_wave (act_wave),
        .act_win  (act_win),
        .act_chg  (act_chg)
    );

    for (genvar p = 0; p < NUM_PULSE; p++) begin : g_lane
        lcb_pulse_lane #(
            .NUM_SEQ  (NUM_SEQ),
            .NUM_MASK (NUM_MASK)
        ) u_lane (
            .clk      (clk),
            .rst      (rst),
            .pix      (pix),
            .line     (line),
            .waves    (act_wave[p]),
            .wins     (act_win[p]),
            .chg      (act_chg),
            .mask_hit (mask_hit[p]),
            .pulse_n  (pulse_n[p])
        );
    end

    assign clamp_n = pulse_n[0];
    assign blank_n = pulse_n[1];

endmodule

// File: rtl/lcb_checker.sv
`timescale 1ns/1ps
module lcb_checker
    import lcb_pkg::*;
#(
    parameter int NUM_SEQ  = 4,
    parameter int NUM_MASK = 3
) (
    input logic                                   clk,
    input logic                                   rst,
    input logic                                   hsync,
    input logic                                   vsync,
    input cnt_t                                   pix,
    input cnt_t                                   line,
    input logic [NUM_PULSE-1:0]                   mask_hit,
    input logic                                   clamp_n,
    input logic                                   blank_n,
    input wave_t   [NUM_PULSE-1:0][NUM_SEQ-1:0]   act_wave,
    input window_t [NUM_PULSE-1:0][NUM_MASK-1:0]  act_win,
    input cnt_t    [NUM_SEQ-2:0]                  act_chg
);

    // R2: any sync restarts the pixel count
    p_pix_restart_r2: assert property (@(posedge clk) disable iff (rst)
        (hsync || vsync) |=> (pix == '0));

    // R2: field sync restarts the line count
    p_line_restart_r2: assert property (@(posedge clk) disable iff (rst)
        vsync |=> (line == '0));

    // R2: line count only moves on a sync
    p_line_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!hsync && !vsync) |=> $stable(line));

    // R9: working bank changes only at field sync
    p_bank_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !vsync |=> ($stable(act_wave) && $stable(act_win) && $stable(act_chg)));

    // R6: a covered line drives the clamp strobe inactive
    p_clamp_masked_r6: assert property (@(posedge clk) disable iff (rst)
        mask_hit[0] |=> clamp_n);

    // R6: a covered line drives the blank strobe inactive
    p_blank_masked_r6: assert property (@(posedge clk) disable iff (rst)
        mask_hit[1] |=> blank_n);

endmodule

bind lcb_line_pulse_gen lcb_checker #(
    .NUM_SEQ  (NUM_SEQ),
    .NUM_MASK (NUM_MASK)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hsync    (hsync),
    .vsync    (vsync),
    .pix      (pix),
    .line     (line),
    .mask_hit (mask_hit),
    .clamp_n  (clamp_n),
    .blank_n  (blank_n),
    .act_wave (act_wave),
    .act_win  (act_win),
    .act_chg  (act_chg)
);

// File: tb/tb_lcb_line_pulse_gen.sv
`timescale 1ns/1ps
module tb_lcb_line_pulse_gen;

    localparam int LINE_PIX  = 40;
    localparam int FIELD_LNS = 12;
    localparam int MAXV      = 8191;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [12:0] wr_data = '0;
    logic        clamp_n;
    logic        blank_n;

    always #2.5 clk = ~clk;

    lcb_line_pulse_gen dut (
        .clk     (clk),
        .rst     (rst),
        .hsync   (hsync),
        .vsync   (vsync),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clamp_n (clamp_n),
        .blank_n (blank_n)
    );

    typedef struct {
        logic  c;
        logic  b;
        string tag;
    } exp_t;

    typedef struct {
        int a;
        int d;
    } wr_t;

    exp_t sb_q[$];
    wr_t  wq[$];

    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    string phase = "R4";

    // bench model of the settings: [strobe][sequence] / [strobe][window]
    bit s_lvl[2][4]; int s_fa[2][4]; int s_fb[2][4];
    int s_ws[2][3];  int s_we[2][3]; int s_chg[3];
    bit a_lvl[2][4]; int a_fa[2][4]; int a_fb[2][4];
    int a_ws[2][3];  int a_we[2][3]; int a_chg[3];
    int m_pix = 0;
    int m_line = 0;

    task automatic check(string req, logic act, logic expv, string what);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b (line %0d)", req, what, act, expv, m_line);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 4; s++) begin
                s_lvl[p][s] = 1; s_fa[p][s] = MAXV; s_fb[p][s] = MAXV;
            end
            for (int w = 0; w < 3; w++) begin
                s_ws[p][w] = MAXV; s_we[p][w] = 0;
            end
        end
        for (int k = 0; k < 3; k++) s_chg[k] = MAXV;
        a_lvl = s_lvl; a_fa = s_fa; a_fb = s_fb;
        a_ws = s_ws; a_we = s_we; a_chg = s_chg;
    endtask

    // R10 address decode, written from the map
    task automatic model_write(int a, int d);
        int sp, sq, p, f, w;
        sp = (a >> 6) & 3;
        p  = (a >> 3) & 1;
        if (sp == 0) begin
            sq = (a >> 4) & 3;
            f  = a & 3;
            if (f == 0) s_lvl[p][sq] = d[0];
            else if (f == 1) s_fa[p][sq] = d;
            else if (f == 2) s_fb[p][sq] = d;
        end else if (sp == 1) begin
            w = (a >> 1) & 3;
            if (w < 3) begin
                if ((a & 1) != 0) s_we[p][w] = d;
                else              s_ws[p][w] = d;
            end
        end else if (sp == 2) begin
            if ((a & 3) < 3) s_chg[a & 3] = d;
        end
    endtask

    function automatic logic model_out(int p, output bit masked, output int sq);
        bit lvl;
        sq = 0;
        for (int k = 0; k < 3; k++) if (m_line >= a_chg[k]) sq++;
        masked = 0;
        // R6 inclusive windows, R7 disable encodings
        for (int w = 0; w < 3; w++)
            if (a_ws[p][w] != MAXV && a_ws[p][w] <= m_line && m_line <= a_we[p][w]) masked = 1;
        // R3 level rule
        lvl = a_lvl[p][sq] ^ (m_pix >= a_fa[p][sq]) ^ (m_pix >= a_fb[p][sq]);
        return masked ? 1'b1 : lvl;
    endfunction

    // driver: one clock of stimulus plus the expected result (R11: seen one edge later)
    task automatic tick(bit hs, bit vs);
        wr_t  w;
        bit   we;
        exp_t e;
        bit   mc, mb;
        int   qc, qb;
        we = 0;
        @(negedge clk);
        rst   = 1'b0;
        hsync = hs;
        vsync = vs;
        if (!vs && wq.size() > 0) begin
            w  = wq.pop_front();
            we = 1;
        end
        wr_en   = we;
        wr_addr = we ? 8'(w.a) : 8'h00;
        wr_data = we ? 13'(w.d) : 13'h0;
        // R2 counter model, R9 bank copy on field sync
        if (vs) begin
            a_lvl = s_lvl; a_fa = s_fa; a_fb = s_fb;
            a_ws = s_ws; a_we = s_we; a_chg = s_chg;
            m_line = 0; m_pix = 0;
        end else if (hs) begin
            m_line = (m_line == MAXV) ? MAXV : m_line + 1;
            m_pix  = 0;
        end else begin
            m_pix = (m_pix == MAXV) ? MAXV : m_pix + 1;
        end
        if (we) model_write(w.a, w.d);
        e.c = model_out(0, mc, qc);
        e.b = model_out(1, mb, qb);
        // R8 when a window hits outside region 0, R5 for later regions
        if (mc || mb) e.tag = (qc != 0) ? "R8" : "R6";
        else if (qc != 0) e.tag = "R5";
        else e.tag = phase;
        sb_q.push_back(e);
    endtask

    task automatic run_line(bit first);
        tick(1'b1, first);
        for (int i = 1; i < LINE_PIX; i++) tick(1'b0, 1'b0);
    endtask

    task automatic run_field();
        run_line(1'b1);
        for (int l = 1; l < FIELD_LNS; l++) run_line(1'b0);
    endtask

    function automatic int wave_addr(int sq, int p, int f);
        return (sq << 4) | (p << 3) | f;
    endfunction

    function automatic int win_addr(int p, int w, int e);
        return 8'h40 | (p << 3) | (w << 1) | e;
    endfunction

    task automatic q_wave(int p, int sq, int lvl, int fa, int fb);
        wq.push_back('{wave_addr(sq, p, 0), lvl});
        wq.push_back('{wave_addr(sq, p, 1), fa});
        wq.push_back('{wave_addr(sq, p, 2), fb});
    endtask

    task automatic q_win(int p, int w, int st, int en);
        wq.push_back('{win_addr(p, w, 0), st});
        wq.push_back('{win_addr(p, w, 1), en});
    endtask

    // monitor: scoreboard compare, one clock behind the driver
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() >= 2) begin
                e = sb_q.pop_front();
                check(e.tag, clamp_n, e.c, "clamp_n");
                check(e.tag, blank_n, e.b, "blank_n");
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(posedge clk);
        // R1: idle outputs under reset
        @(negedge clk);
        check("R1", clamp_n, 1'b1, "clamp_n in reset");
        check("R1", blank_n, 1'b1, "blank_n in reset");

        // settings staged during a default field: R9 (no effect yet), R4 all high
        q_wave(0, 0, 1, 2, 8);
        q_wave(1, 0, 1, 0, 30);
        q_wave(0, 1, 0, 10, 20);
        q_wave(1, 1, 1, 25, 15);          // R3: second flip before first
        q_wave(0, 2, 1, 35, MAXV);         // R3: flip never reached
        q_wave(1, 2, 1, 12, 18);
        q_wave(0, 3, 1, 0, 39);
        q_wave(1, 3, 0, MAXV, MAXV);
        wq.push_back('{8'h80, 3});
        wq.push_back('{8'h81, 6});
        wq.push_back('{8'h82, 9});
        wq.push_back('{8'h83, 1});         // R10: unused change slot
        wq.push_back('{8'hC5, 0});         // R10: unmapped space
        wq.push_back('{wave_addr(0, 0, 3), 0}); // R10: spare field
        q_win(0, 0, 4, 5);                 // R6 / R8: spans region 1
        q_win(0, 1, 20, 30);               // R7: beyond field length
        q_win(0, 2, 10, 8);                // R7: start above end
        q_win(1, 0, 0, 0);                 // R6: single line, inclusive
        q_win(1, 1, 11, 11);               // R8: region 3
        q_win(1, 2, MAXV, MAXV);           // R7: start at 8191
        wq.push_back('{8'h47, 7});         // R10: window slot 3 ignored
        phase = "R9";
        run_field();

        // programmed field: R3, R5, R6, R7, R8; mid-field changes staged
        phase = "R3";
        run_line(1'b1);
        q_wave(0, 0, 0, 5, 15);
        q_win(0, 0, MAXV, 0);
        wq.push_back('{8'h80, 2});
        for (int l = 1; l < FIELD_LNS; l++) run_line(1'b0);

        // R9: staged changes now in force
        phase = "R9";
        run_field();

        // R2: a long line drives the pixel count past the line length
        phase = "R2";
        run_line(1'b1);
        for (int i = 0; i < 60; i++) tick(1'b0, 1'b0);

        repeat (3) @(posedge clk);
        #1;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule